// File: doc/BRIEF.md
# Separable Virtual-Channel Switch Allocator

This block decides, every clock cycle, which buffered flits of a virtual-channel router cross the crossbar. The router has `NPORT` ports and `NVC` virtual channels per input port. Each input VC presents four things: a request flag, the output port it wants, a flag marking the request as speculative (a head flit whose output VC is not yet secured), and a flag saying the downstream output VC has a credit. The allocator returns a one-hot VC grant for each input port and a one-hot input select for each output port. The select drives the crossbar multiplexers directly.

Matching is separable and input-first. In the first stage, a round-robin arbiter at each input picks one eligible VC. In the second stage, a round-robin arbiter at each output picks one of the inputs whose first-stage winner targets it. Requests without a credit never take part. Non-speculative requests beat speculative ones at both stages: a speculative candidate is looked at only when no non-speculative one exists. Body and tail flits therefore always compete at the higher class.

Grants are pure combinational functions of the current requests and the arbiter pointers. The only state is one pointer per arbiter, so a grant has no path back into a request within the same cycle.

Top module: `sw_alloc`

## Requirements
- R1: Grants depend combinationally on the present inputs and pointer state. Input VC `v` of port `i` uses flat index `k = i*NVC+v`: bit `k` of `req_vld`, `req_spec`, `req_credit` and `vc_gnt`, and bits `[k*PW +: PW]` of `req_port`.
- R2: At most one bit of `vc_gnt[i*NVC +: NVC]` is set for each input port `i`.
- R3: `out_sel[o*NPORT + i]` selects input `i` for output `o`, and at most one bit of `out_sel[o*NPORT +: NPORT]` is set for each output `o`.
- R4: Grants agree at both ends: VC `k` of input `i` is granted exactly when `out_sel[o*NPORT+i]` is set for the output `o` it requested.
- R5: A VC whose `req_credit` is 0 is never granted, and it does not block other VCs.
- R6: At an input, a valid, credited VC with `req_spec`=0 always wins over any speculative VC of the same input, whatever the pointer state.
- R7: At an output, an input carrying a non-speculative request always wins over inputs carrying speculative ones, whatever the pointer state.
- R8: Every arbiter is round-robin. After reset the search starts at index 0. After a grant, the granted index becomes the lowest priority for the next cycle.
- R9: With no valid request, `vc_gnt` and `out_sel` are all zero.
- R10: An input arbiter's pointer advances only when its chosen VC also wins at the output. A VC that loses at the output is picked again first in the next cycle.
- R11: A speculative request with no non-speculative competitor at its input or at its output is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the arbiter pointers |
| req_vld | input | NPORT*NVC | Request flag per input VC |
| req_port | input | NPORT*NVC*PW | Requested output port per input VC |
| req_spec | input | NPORT*NVC | Request is speculative (output VC not yet allocated) |
| req_credit | input | NPORT*NVC | Downstream credit available for the VC's output VC |
| vc_gnt | output | NPORT*NVC | One-hot VC grant per input port |
| out_sel | output | NPORT*NPORT | One-hot input select per output port for the crossbar |

## Verification
The hardest state to reach from the ports is an input arbiter whose choice was overruled at the output, because that only shows up as a pointer that failed to move. The stimulus gets there in three steps. It first grants a different input at the target output, which turns that output's pointer away from the input under test. In the next cycle it collides a two-VC input with that favoured input, so the input under test loses at the output. It then presents the two VCs alone and expects the same VC to win again. The class-priority checks are set up in a similar way: the speculative requester sits at index 0, where a fresh pointer would favour it, so only the class rule can make it lose.

// File: rtl/sa_pkg.sv
package sa_pkg;
  // Priority class of a request inside an arbitration stage.
  typedef enum logic {
    CLS_FIRM = 1'b0,
    CLS_SPEC = 1'b1
  } req_class_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sa_rr_arb.sv
module sa_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  localparam int IW = sa_pkg::idx_w(N);

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] ptr_d;
  logic [IW-1:0] win_idx;
  logic          found;
  logic          ptr_en;

  // Search from the pointer upward with wrap; the first request found wins.
  always_comb begin
    gnt     = '0;
    win_idx = '0;
    found   = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        win_idx  = IW'(idx);
        found    = 1'b1;
      end
    end
  end

  assign ptr_en = adv & found;

  always_comb begin
    ptr_d = ptr_q;
    if (win_idx == IW'(N - 1)) ptr_d = '0;
    else                       ptr_d = win_idx + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  // R8: a grant is one-hot and only goes to a requester
  p_arb_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0));

  // R8: any request yields a grant
  p_arb_work_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));
endmodule

// File: rtl/sa_class_arb.sv
module sa_class_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_firm,
  input  logic [N-1:0] req_spec,
  input  logic         adv,
  output logic [N-1:0] gnt,
  output sa_pkg::req_class_e gnt_cls
);
  import sa_pkg::*;

  logic          firm_any;
  logic [N-1:0]  req_pick;

  // The speculative vector is considered only when no firm request exists.
  assign firm_any = |req_firm;
  assign req_pick = firm_any ? req_firm : req_spec;
  assign gnt_cls  = firm_any ? CLS_FIRM : CLS_SPEC;

  sa_rr_arb #(.N(N)) u_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_pick),
    .adv   (adv),
    .gnt   (gnt)
  );

  // R6/R7: with a firm request present, the grant never lands on a speculative-only bit
  p_firm_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    firm_any |-> ((gnt & ~req_firm) == '0));

  // R11: speculative requests alone still obtain a grant
  p_spec_served_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!firm_any && (|req_spec)) |-> ((gnt & req_spec) != '0));
endmodule

// File: rtl/sw_alloc.sv
module sw_alloc #(
  parameter int NPORT = 4,
  parameter int NVC   = 2,
  parameter int PW    = sa_pkg::idx_w(NPORT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT*NVC-1:0]   req_vld,
  input  logic [NPORT*NVC*PW-1:0] req_port,
  input  logic [NPORT*NVC-1:0]   req_spec,
  input  logic [NPORT*NVC-1:0]   req_credit,
  output logic [NPORT*NVC-1:0]   vc_gnt,
  output logic [NPORT*NPORT-1:0] out_sel
);
  import sa_pkg::*;

  localparam int NREQ = NPORT * NVC;

  logic [NREQ-1:0]             elig;
  logic [NPORT-1:0][NVC-1:0]   in_firm;
  logic [NPORT-1:0][NVC-1:0]   in_specv;
  logic [NPORT-1:0][NVC-1:0]   in_gnt;
  req_class_e                  in_cls [NPORT];
  logic [NPORT-1:0]            in_act;
  logic [NPORT-1:0][PW-1:0]    port_of;
  logic [NPORT-1:0][NPORT-1:0] out_firm;
  logic [NPORT-1:0][NPORT-1:0] out_specv;
  logic [NPORT-1:0][NPORT-1:0] out_gnt;
  logic [NPORT-1:0]            in_won;
  req_class_e                  out_cls [NPORT];

  // Only credited requests take part at all.
  assign elig = req_vld & req_credit;

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      for (int v = 0; v < NVC; v++) begin
        in_firm[i][v]  = elig[i*NVC+v] & ~req_spec[i*NVC+v];
        in_specv[i][v] = elig[i*NVC+v] &  req_spec[i*NVC+v];
      end
    end
  end

  // Stage one: one VC per input.
  for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
    sa_class_arb #(.N(NVC)) u_in_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_firm (in_firm[gi]),
      .req_spec (in_specv[gi]),
      .adv      (in_won[gi]),
      .gnt      (in_gnt[gi]),
      .gnt_cls  (in_cls[gi])
    );
  end

  // Requested output port of each input's stage-one winner.
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      port_of[i] = '0;
      for (int v = 0; v < NVC; v++) begin
        if (in_gnt[i][v]) port_of[i] = port_of[i] | req_port[(i*NVC+v)*PW +: PW];
      end
      in_act[i] = |in_gnt[i];
    end
  end

  // Requests seen by each output, split by class.
  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        out_firm[o][i]  = in_act[i] && (in_cls[i] == CLS_FIRM) && (port_of[i] == PW'(o));
        out_specv[o][i] = in_act[i] && (in_cls[i] == CLS_SPEC) && (port_of[i] == PW'(o));
      end
    end
  end

  // Stage two: one input per output.
  for (genvar go = 0; go < NPORT; go++) begin : g_out
    sa_class_arb #(.N(NPORT)) u_out_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_firm (out_firm[go]),
      .req_spec (out_specv[go]),
      .adv      (1'b1),
      .gnt      (out_gnt[go]),
      .gnt_cls  (out_cls[go])
    );
  end

  always_comb begin
    in_won = '0;
    for (int o = 0; o < NPORT; o++) begin
      in_won = in_won | out_gnt[o];
    end
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      vc_gnt[i*NVC +: NVC] = in_gnt[i] & {NVC{in_won[i]}};
    end
    for (int o = 0; o < NPORT; o++) begin
      out_sel[o*NPORT +: NPORT] = out_gnt[o];
    end
  end

  // ---------------- assertions ----------------
  for (genvar ai = 0; ai < NPORT; ai++) begin : g_chk_in
    // R2: one VC per input
    p_one_vc_per_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(vc_gnt[ai*NVC +: NVC]));
  end

  for (genvar ao = 0; ao < NPORT; ao++) begin : g_chk_out
    // R3: one input per output
    p_one_in_per_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_sel[ao*NPORT +: NPORT]));
  end

  // R4: both sides of the match count the same number of grants
  p_match_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vc_gnt) == $countones(out_sel));

  // R5: no grant without a request and a credit
  p_gnt_needs_credit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vc_gnt & ~(req_vld & req_credit)) == '0);

  // R9: idle means no grants
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld == '0) |-> ((vc_gnt == '0) && (out_sel == '0)));
endmodule

// File: tb/sw_alloc_bench.sv
`timescale 1ns/100ps
module sw_alloc_bench;
  localparam int NP = 4;
  localparam int NV = 2;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [NP*NV-1:0]    req_vld;
  logic [NP*NV*PW-1:0] req_port;
  logic [NP*NV-1:0]    req_spec;
  logic [NP*NV-1:0]    req_credit;
  logic [NP*NV-1:0]    vc_gnt;
  logic [NP*NP-1:0]    out_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sw_alloc #(.NPORT(NP), .NVC(NV)) u_sw_alloc (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_port(req_port),
    .req_spec(req_spec), .req_credit(req_credit), .vc_gnt(vc_gnt), .out_sel(out_sel)
  );

  function automatic logic [NP*NV-1:0] vg(input int i, input int v);
    return (NP*NV)'(1) << (i*NV + v);
  endfunction

  function automatic logic [NP*NP-1:0] os(input int o, input int i);
    return (NP*NP)'(1) << (o*NP + i);
  endfunction

  task automatic clear_reqs();
    req_vld = '0; req_port = '0; req_spec = '0; req_credit = '0;
  endtask

  task automatic set_req(input int i, input int v, input int p, input bit sp, input bit cr);
    req_vld[i*NV+v]        = 1'b1;
    req_port[(i*NV+v)*PW +: PW] = PW'(p);
    req_spec[i*NV+v]       = sp;
    req_credit[i*NV+v]     = cr;
  endtask

  // Applies reset; leaves the bench just after a falling edge with reset released.
  task automatic do_reset();
    clear_reqs();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Inputs already driven after a falling edge; sample 1 ns later, then wait for the next falling edge.
  task automatic check(input string req, input logic [NP*NV-1:0] exp_vc,
                       input logic [NP*NP-1:0] exp_os);
    #1;
    n_chk++;
    if (vc_gnt !== exp_vc || out_sel !== exp_os) begin
      n_bad++;
      $display("FAIL %s: vc_gnt=%b out_sel=%b expected vc_gnt=%b out_sel=%b",
               req, vc_gnt, out_sel, exp_vc, exp_os);
    end
    @(negedge clk);
  endtask

  task automatic t_idle();
    do_reset();
    check("R9 idle after reset", '0, '0);
    set_req(1, 0, 2, 1'b0, 1'b1);
    req_vld = '0;
    check("R9 fields set without valid", '0, '0);
  endtask

  task automatic t_basic();
    do_reset();
    set_req(0, 1, 3, 1'b0, 1'b1);
    set_req(2, 0, 1, 1'b0, 1'b1);
    check("R1 R4 two disjoint matches", vg(0,1) | vg(2,0), os(3,0) | os(1,2));
    clear_reqs();
    set_req(3, 1, 0, 1'b0, 1'b1);
    check("R1 follows inputs in same cycle", vg(3,1), os(0,3));
  endtask

  task automatic t_credit();
    do_reset();
    set_req(1, 0, 0, 1'b0, 1'b0);
    check("R5 uncredited alone", '0, '0);
    set_req(1, 1, 2, 1'b0, 1'b1);
    check("R5 credited sibling served", vg(1,1), os(2,1));
  endtask

  task automatic t_in_prio();
    do_reset();
    set_req(1, 0, 2, 1'b1, 1'b1);
    set_req(1, 1, 3, 1'b0, 1'b1);
    check("R6 firm VC beats speculative", vg(1,1), os(3,1));
    check("R6 firm VC beats speculative again", vg(1,1), os(3,1));
  endtask

  task automatic t_out_prio();
    do_reset();
    set_req(0, 0, 1, 1'b1, 1'b1);
    set_req(3, 0, 1, 1'b0, 1'b1);
    check("R7 firm input beats speculative at output", vg(3,0), os(1,3));
    clear_reqs();
    set_req(0, 0, 1, 1'b1, 1'b1);
    check("R11 speculative alone granted", vg(0,0), os(1,0));
  endtask

  task automatic t_out_rr();
    do_reset();
    set_req(0, 0, 0, 1'b0, 1'b1);
    set_req(1, 0, 0, 1'b0, 1'b1);
    check("R3 R8 output conflict first", vg(0,0), os(0,0));
    check("R3 R8 output conflict rotates", vg(1,0), os(0,1));
    check("R8 output conflict wraps", vg(0,0), os(0,0));
  endtask

  task automatic t_vc_rr();
    do_reset();
    set_req(2, 0, 3, 1'b0, 1'b1);
    set_req(2, 1, 3, 1'b0, 1'b1);
    check("R2 R8 vc rr first", vg(2,0), os(3,2));
    check("R2 R8 vc rr second", vg(2,1), os(3,2));
    check("R8 vc rr wraps", vg(2,0), os(3,2));
  endtask

  task automatic t_hold();
    do_reset();
    set_req(1, 0, 2, 1'b0, 1'b1);
    check("R10 prime output pointer", vg(1,0), os(2,1));
    clear_reqs();
    set_req(0, 0, 2, 1'b0, 1'b1);
    set_req(0, 1, 2, 1'b0, 1'b1);
    set_req(2, 0, 2, 1'b0, 1'b1);
    check("R10 input loses at output", vg(2,0), os(2,2));
    clear_reqs();
    set_req(0, 0, 2, 1'b0, 1'b1);
    set_req(0, 1, 2, 1'b0, 1'b1);
    check("R10 input pointer held", vg(0,0), os(2,0));
  endtask

  initial begin
    rst_n = 1'b0;
    clear_reqs();
    t_idle();
    t_basic();
    t_credit();
    t_in_prio();
    t_out_prio();
    t_out_rr();
    t_vc_rr();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule